// File: doc/BRIEF.md
# I2C Master SCL Clock Divider with Stretch Tracking

This block produces the serial clock for an I2C master. A 6-bit divider code picks how many system clocks make up one SCL period. Each code resolves to a base count and a power-of-two prescaler, and the period is their product. The prescaler emits one tick every `2^k` system clocks. The low phase lasts the upper half of the base count in ticks, and the high phase lasts the lower half. An odd base therefore gives its spare tick to the low phase.

SCL is driven as an open-drain line. The block either pulls the line low or lets it go. The real line is looked at only on prescaler ticks. After release, the high-phase tick count does not start until a tick finds the line high. A slave that holds SCL low, or a line that rises slowly, therefore lengthens the period by whole ticks.

A new code is picked up only when the block drives the next falling edge, so a running period is never cut short. Clearing the enable lets the line go and returns the counters to their start. The block pulses a strobe for one cycle each time it completes a period.

Top module: `scl_clock_gen`

## Requirements
- R1: Codes 0x20..0x2B give base×prescaler splits 10×2, 11×2, 12×2, 13×2, 14×2, 16×2, 18×2, 10×4, 12×4, 14×4, 16×4, 18×4. For example, 0x23 gives 26 clocks, 0x26 gives 36, and 0x2B gives 72.
- R2: Codes 0x2C..0x3F give a base of 10, 12, 14, 16 in turn (code bits [1:0] = 0..3). The prescaler starts at 8 and doubles every four codes: 0x2C = 10×8, 0x32 = 14×16, 0x3F = 16×128.
- R3: Codes 0x00..0x0C give splits 14×2, 15×2, 17×2, then 10/11/12/14/17×4, then 10/11/13/16/18×8. For example, 0x07 = 17×4 and 0x0C = 18×8.
- R4: Codes 0x0D..0x1F give a base of 10, 12, 15, 18 in turn. The prescaler starts at 16 and doubles every four codes: 0x0D = 10×16, 0x0E = 12×16, 0x0F = 15×16, 0x1F = 15×256.
- R5: With no stretching, the low phase (pull-low output = 1) lasts ceil(base/2)×prescaler system clocks and the high phase lasts floor(base/2)×prescaler system clocks. An odd base puts its extra tick in the low phase.
- R6: The line is sampled only on prescaler ticks. The high-phase count starts at the first tick that reads SCL high, and ends the phase after floor(base/2) high ticks. If the line first reads high at tick k0 after release, the high phase lasts (k0 + floor(base/2) − 1)×prescaler system clocks.
- R7: When the enable is low, the pull-low output is 0 from the next cycle onward, no strobe is produced, and the counters are cleared. The first period after the enable rises is complete and exact.
- R8: A code change made during a period takes effect only from the next falling edge the block drives. The running period keeps the old split.
- R9: The strobe is high for exactly one cycle at the end of each period. It coincides with the first cycle in which the pull-low output is 1 again.
- R10: After synchronous reset, the pull-low output and the strobe are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low releases SCL and clears counters |
| div_code | input | 6 | Divider code selecting base and prescaler |
| scl_in | input | 1 | SCL line level, already synchronous to clk |
| scl_pull_low | output | 1 | 1 pulls SCL low, 0 releases it |
| period_strobe | output | 1 | One-cycle pulse at the end of each SCL period |

## Verification
The line model is ideal at first and is swept over codes from all four table regions. Both odd and even bases are included, so a wrong table entry, a wrong prescaler step or a misplaced odd tick shows up as a wrong low or high length. The same model is then given slave hold times that are shorter than, just past, and many times one prescaler tick. This separates sampling every clock from sampling on ticks, and shows whether the high count waits for a high reading. Codes are also changed in the middle of a period and the enable is dropped in the middle of a period. This shows whether a split is swapped before the falling edge and whether a restart begins from cleared counters.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

    localparam int CODE_W  = 6;
    localparam int BASE_W  = 5;   // base counts up to 18
    localparam int PLOG_W  = 4;   // prescaler exponent up to 8
    localparam int PRE_W   = 8;   // prescaler counter width (max 256)
    localparam int HALF_W  = BASE_W - 1;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [PLOG_W-1:0] plog;
    } scl_cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

    function automatic scl_cfg_t mk_cfg(int b, int p);
        scl_cfg_t c;
        c.base = BASE_W'(b);
        c.plog = PLOG_W'(p);
        return c;
    endfunction

    // Split a divider code into base count and prescaler exponent.
    function automatic scl_cfg_t scl_decode(logic [CODE_W-1:0] code);
        scl_cfg_t   c;
        logic [5:0] idx;
        int         b4 [4];
        c   = mk_cfg(10, 1);
        idx = '0;
        if (code <= 6'h02) begin
            case (code[1:0])
                2'd0:    c = mk_cfg(14, 1);
                2'd1:    c = mk_cfg(15, 1);
                default: c = mk_cfg(17, 1);
            endcase
        end else if (code <= 6'h07) begin
            case (code)
                6'h03:   c = mk_cfg(10, 2);
                6'h04:   c = mk_cfg(11, 2);
                6'h05:   c = mk_cfg(12, 2);
                6'h06:   c = mk_cfg(14, 2);
                default: c = mk_cfg(17, 2);
            endcase
        end else if (code <= 6'h0C) begin
            case (code)
                6'h08:   c = mk_cfg(10, 3);
                6'h09:   c = mk_cfg(11, 3);
                6'h0A:   c = mk_cfg(13, 3);
                6'h0B:   c = mk_cfg(16, 3);
                default: c = mk_cfg(18, 3);
            endcase
        end else if (code <= 6'h1F) begin
            idx = code - 6'h0D;
            b4  = '{10, 12, 15, 18};
            c   = mk_cfg(b4[idx[1:0]], 4 + int'(idx[4:2]));
        end else if (code <= 6'h26) begin
            case (code)
                6'h20:   c = mk_cfg(10, 1);
                6'h21:   c = mk_cfg(11, 1);
                6'h22:   c = mk_cfg(12, 1);
                6'h23:   c = mk_cfg(13, 1);
                6'h24:   c = mk_cfg(14, 1);
                6'h25:   c = mk_cfg(16, 1);
                default: c = mk_cfg(18, 1);
            endcase
        end else if (code <= 6'h2B) begin
            case (code)
                6'h27:   c = mk_cfg(10, 2);
                6'h28:   c = mk_cfg(12, 2);
                6'h29:   c = mk_cfg(14, 2);
                6'h2A:   c = mk_cfg(16, 2);
                default: c = mk_cfg(18, 2);
            endcase
        end else begin
            idx = code - 6'h2C;
            b4  = '{10, 12, 14, 16};
            c   = mk_cfg(b4[idx[1:0]], 3 + int'(idx[4:2]));
        end
        return c;
    endfunction

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler
    import scl_div_pkg::*;
#(
    parameter int CNT_W = PRE_W,
    parameter int EXP_W = PLOG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [EXP_W-1:0] plog,
    output logic             tick
);
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] last;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        span = (CNT_W+1)'(1) << plog;
        last = CNT_W'(span - (CNT_W+1)'(1));
    end

    assign tick = (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + CNT_W'(1);
    end

    // R5
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr) |=> !tick);
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic              scl_in,
    input  logic [BASE_W-1:0] base,
    output logic              idle,
    output logic              load,
    output logic              pull_low,
    output logic              done
);
    scl_phase_e        state;
    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] low_len;
    logic [HALF_W-1:0] high_len;
    logic              low_end;
    logic              high_end;

    always_comb begin
        low_len  = HALF_W'((base + BASE_W'(1)) >> 1);
        high_len = HALF_W'(base >> 1);
        low_end  = (state == PH_LOW)  && tick && (cnt + HALF_W'(1) == low_len);
        high_end = (state == PH_HIGH) && tick && scl_in
                   && (cnt + HALF_W'(1) == high_len);
        idle     = (state == PH_IDLE);
        load     = idle || high_end;
        pull_low = (state == PH_LOW);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state <= PH_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                PH_IDLE: begin
                    state <= PH_LOW;
                    cnt   <= '0;
                end
                PH_LOW: begin
                    if (low_end) begin
                        state <= PH_HIGH;
                        cnt   <= '0;
                    end else if (tick) begin
                        cnt <= cnt + HALF_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (high_end) begin
                        state <= PH_LOW;
                        cnt   <= '0;
                        done  <= 1'b1;
                    end else if (tick && scl_in) begin
                        cnt <= cnt + HALF_W'(1);
                    end
                end
                default: state <= PH_IDLE;
            endcase
        end
    end

    // R6
    stretch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !pull_low && !idle && tick && !scl_in) |=> !pull_low);
    // R7
    disable_release_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!pull_low && !done));
    // R9
    strobe_edge_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> pull_low);
    // R9
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
    import scl_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [CODE_W-1:0] div_code,
    input  logic              scl_in,
    output logic              scl_pull_low,
    output logic              period_strobe
);
    scl_cfg_t cfg_q;
    logic     tick;
    logic     idle;
    logic     load;

    // Active split changes only at a driven falling edge or while stopped.
    always_ff @(posedge clk) begin
        if (rst)              cfg_q <= scl_decode(div_code);
        else if (!en || load) cfg_q <= scl_decode(div_code);
    end

    scl_prescaler #(
        .CNT_W (PRE_W),
        .EXP_W (PLOG_W)
    ) i_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (idle || !en),
        .plog (cfg_q.plog),
        .tick (tick)
    );

    scl_phase_fsm i_fsm (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .tick     (tick),
        .scl_in   (scl_in),
        .base     (cfg_q.base),
        .idle     (idle),
        .load     (load),
        .pull_low (scl_pull_low),
        .done     (period_strobe)
    );

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !load) |=> $stable(cfg_q));
    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!scl_pull_low && !period_strobe));
endmodule

// File: tb/test_scl_clock_gen.sv
module test_scl_clock_gen;

    typedef struct {
        int    lo;
        int    hi;
        int    code;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [5:0] div_code = 6'h20;
    logic       scl_in;
    logic       scl_pull_low;
    logic       period_strobe;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   strobes  = 0;
    int   target   = 0;
    int   stretch  = 0;
    int   hold     = 0;
    bit   running  = 0;
    logic [5:0] cur_code = 6'h20;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    scl_clock_gen i_scl_clock_gen (
        .clk           (clk),
        .rst           (rst),
        .en            (en),
        .div_code      (div_code),
        .scl_in        (scl_in),
        .scl_pull_low  (scl_pull_low),
        .period_strobe (period_strobe)
    );

    // Open-drain line with a slave that holds SCL low for `stretch` clocks.
    assign scl_in = !scl_pull_low && (hold == 0);
    always @(posedge clk) begin
        if (rst)               hold <= 0;
        else if (scl_pull_low) hold <= stretch;
        else if (hold > 0)     hold <= hold - 1;
    end

    // Expected split per the requirement lists (R1..R4).
    function automatic void split(input logic [5:0] c, output int b, output int m);
        case (c)
            6'h00: begin b = 14; m = 2;   end  // R3
            6'h01: begin b = 15; m = 2;   end  // R3
            6'h07: begin b = 17; m = 4;   end  // R3
            6'h0C: begin b = 18; m = 8;   end  // R3
            6'h0D: begin b = 10; m = 16;  end  // R4
            6'h0E: begin b = 12; m = 16;  end  // R4
            6'h0F: begin b = 15; m = 16;  end  // R4
            6'h1F: begin b = 15; m = 256; end  // R4
            6'h20: begin b = 10; m = 2;   end  // R1
            6'h23: begin b = 13; m = 2;   end  // R1
            6'h26: begin b = 18; m = 2;   end  // R1
            6'h2B: begin b = 18; m = 4;   end  // R1
            6'h2C: begin b = 10; m = 8;   end  // R2
            6'h32: begin b = 14; m = 16;  end  // R2
            6'h3F: begin b = 16; m = 128; end  // R2
            default: begin b = 0; m = 0;  end
        endcase
    endfunction

    // R5 / R6 timing model
    function automatic exp_t expect_of(input logic [5:0] c, input int s, input string tag);
        exp_t e;
        int b, m, k0;
        split(c, b, m);
        k0 = (s + 1 + m - 1) / m;
        if (k0 < 1) k0 = 1;
        e.lo   = ((b + 1) / 2) * m;
        e.hi   = (k0 + b / 2 - 1) * m;
        e.code = int'(c);
        e.tag  = tag;
        return e;
    endfunction

    task automatic start(input logic [5:0] c, input int n, input int s, input string tag);
        @(posedge clk); #1;
        stretch  = s;
        div_code = c;
        en       = 1'b1;
        for (int i = 0; i < n; i++) exp_q.push_back(expect_of(c, s, tag));
        target   = strobes + n;
        cur_code = c;
        running  = 1;
        wait (strobes >= target);
    endtask

    task automatic seg(input logic [5:0] c, input int n, input int s, input int dly,
                       input string tag);
        @(posedge clk); #1;
        repeat (dly) @(posedge clk);
        #1;
        stretch  = s;
        div_code = c;
        // R8: the period already running keeps the previous split
        exp_q.push_back(expect_of(cur_code, s, tag));
        for (int i = 0; i < n; i++) exp_q.push_back(expect_of(c, s, tag));
        target   = strobes + n + 1;
        cur_code = c;
        wait (strobes >= target);
    endtask

    // Monitor: measure low/high lengths between strobes and compare.
    int lo_cnt = 0;
    int hi_cnt = 0;
    always @(negedge clk) begin
        if (!en || rst) begin
            lo_cnt = 0;
            hi_cnt = 0;
        end else begin
            if (period_strobe) begin
                exp_t e;
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R9 unexpected strobe: actual lo=%0d hi=%0d expected none",
                             lo_cnt, hi_cnt);
                end else begin
                    e = exp_q.pop_front();
                    if (lo_cnt != e.lo || hi_cnt != e.hi) begin
                        n_fail++;
                        $display("FAIL %s code=0x%02h: actual lo=%0d hi=%0d expected lo=%0d hi=%0d",
                                 e.tag, e.code, lo_cnt, hi_cnt, e.lo, e.hi);
                    end
                end
                strobes++;
                lo_cnt = 0;
                hi_cnt = 0;
            end
            if (scl_pull_low)    lo_cnt++;
            else if (lo_cnt > 0) hi_cnt++;
        end
    end

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        bit bad;
        repeat (4) @(posedge clk);
        #1;
        // R10: reset state
        @(negedge clk);
        n_checks++;
        if (scl_pull_low !== 1'b0 || period_strobe !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 reset: actual pull=%b strobe=%b expected 0 0",
                     scl_pull_low, period_strobe);
        end
        @(posedge clk); #1;
        rst = 1'b0;

        start(6'h20, 3, 0, "R1");
        seg(6'h23, 3, 0, 0, "R1");
        seg(6'h26, 2, 0, 0, "R1");
        seg(6'h2B, 2, 0, 0, "R1");
        seg(6'h2C, 2, 0, 0, "R2");
        seg(6'h32, 2, 0, 0, "R2");
        seg(6'h3F, 2, 0, 0, "R2");
        seg(6'h00, 2, 0, 0, "R3");
        seg(6'h01, 2, 0, 0, "R5");   // odd base: extra tick low
        seg(6'h07, 2, 0, 0, "R3");
        seg(6'h0C, 2, 0, 0, "R3");
        seg(6'h0D, 2, 0, 0, "R4");
        seg(6'h0E, 2, 0, 0, "R4");
        seg(6'h0F, 2, 0, 0, "R5");
        seg(6'h1F, 2, 0, 0, "R4");
        // R6: stretching at tick resolution
        seg(6'h0E, 2, 20, 0, "R6");
        seg(6'h20, 2, 5, 0, "R6");
        seg(6'h2C, 2, 300, 0, "R6");
        // R8: change in the middle of a period
        seg(6'h2B, 2, 0, 7, "R8");
        seg(6'h23, 2, 0, 3, "R8");

        // R7: drop enable mid-period, line must be released, no strobe
        @(posedge clk); #1;
        repeat (9) @(posedge clk);
        #1;
        en = 1'b0;
        running = 0;
        @(negedge clk);
        @(negedge clk);
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            if (scl_pull_low !== 1'b0 || period_strobe !== 1'b0) bad = 1;
            @(negedge clk);
        end
        n_checks++;
        if (bad) begin
            n_fail++;
            $display("FAIL R7 disabled: actual pull/strobe active expected released and quiet");
        end
        // R7: restart gives exact periods
        start(6'h0D, 2, 0, "R7");

        repeat (5) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R9 pending periods: actual %0d expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule